// File: doc/BRIEF.md
# Two-Operand Integer ALU with Zero Detect

This block is a combinational arithmetic logic unit for a simple integer datapath. It takes two operands and a three-bit operation code, and it returns a result word and a flag that goes high when that result is all zeros. It provides five operations: bitwise AND, bitwise OR, wrapping addition, wrapping subtraction, and a signed less-than compare that returns 1 or 0.

Addition and subtraction share one adder. Subtraction adds the inverted second operand plus one. The compare reads the sign of that difference and corrects it when the subtraction overflows. A control stage upstream picks the operation code, and a branch unit downstream reads the zero flag to test operands for equality. The block has no clock and holds no state. The three codes it does not use give a defined result of zero.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of operand A and operand B.
- R2: Operation code 3'b001 drives the result with the bitwise OR of A and B.
- R3: Operation code 3'b010 drives the result with A plus B, truncated to WIDTH bits; a carry out of the top bit is dropped and nothing else shows it.
- R4: Operation code 3'b110 drives the result with A minus B modulo 2^WIDTH (for example 0x00000011 minus 0x00000044 gives 0xFFFFFFCD).
- R5: Operation code 3'b111 drives the result with 1 when A is less than B, both read as two's-complement signed values, and with 0 otherwise. Bits above bit 0 are always zero, so 0xFFFFFFFF compares below 0x00000001. The answer stays correct when A minus B overflows.
- R6: The zero output is 1 exactly when every result bit is 0, for every operation code.
- R7: Operation codes 3'b011, 3'b100 and 3'b101 drive a result of 0, and so the zero output reads 1.
- R8: The outputs depend only on the present inputs. After the inputs change, the new result appears with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A (first operand, minuend) |
| b_i | input | WIDTH | Operand B (second operand, subtrahend) |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds the block with WIDTH at its default of 32 and ZCHUNK at 8. The zero detector therefore has four leaf groups, and a stray bit in any byte must clear the flag. At this width the bench can reach the signed boundaries 0x7FFFFFFF and 0x80000000 directly. That exposes the overflow cases of the compare, the wrap of addition to zero, and subtraction of equal operands. Every code, including the three unused ones, runs over a grid of corner operands and a random sweep.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  // Signed overflow of a sum, given the sign bits of the two addends and of the sum
  function automatic logic fn_add_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Signed less-than from the sign of the difference, corrected by overflow
  function automatic logic fn_less(input logic diff_sign, input logic ovf);
    return diff_sign ^ ovf;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             less_o
);
  import alu_pkg::*;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin_w;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    cin_w  = '0;
    cin_w[0] = sub_i;
    sum_o  = a_i + b_eff + cin_w;
    ovf_o  = fn_add_ovf(a_i[WIDTH-1], b_eff[WIDTH-1], sum_o[WIDTH-1]);
    less_o = fn_less(sum_o[WIDTH-1], ovf_o);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] out_o
);
  always_comb begin
    out_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH  = 32,
  parameter int ZCHUNK = 8
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  localparam int NCHUNK = (WIDTH + ZCHUNK - 1) / ZCHUNK;
  localparam int PADW   = NCHUNK * ZCHUNK;

  logic [PADW-1:0]   padded;
  logic [NCHUNK-1:0] chunk_any;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = val_i;
  end

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*ZCHUNK +: ZCHUNK];
  end

  assign zero_o = ~|chunk_any;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH  = 32,
  parameter int ZCHUNK = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  import alu_pkg::*;

  logic [WIDTH-1:0] sum_w;
  logic             ovf_w;
  logic             less_w;
  logic [WIDTH-1:0] logic_w;
  logic [WIDTH-1:0] slt_w;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(op_i[2]),
    .sum_o(sum_w), .ovf_o(ovf_w), .less_o(less_w)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_or_i(op_i[0]), .out_o(logic_w)
  );

  always_comb begin
    slt_w    = '0;
    slt_w[0] = less_w;
    case (op_i)
      OP_AND, OP_OR:  result_o = logic_w;
      OP_ADD, OP_SUB: result_o = sum_w;
      OP_SLT:         result_o = slt_w;
      default:        result_o = '0;
    endcase
  end

  alu_zero_detect #(.WIDTH(WIDTH), .ZCHUNK(ZCHUNK)) u_zero (
    .val_i(result_o), .zero_o(zero_o)
  );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_w
);
  logic known;
  always_comb begin
    known = !$isunknown({a_i, b_i, op_i});
    if (known) begin
      AST_AND_SUBSET: assert (op_i != 3'b000 || ((result_o & ~a_i) == '0 && (result_o & ~b_i) == '0)); // R1
      AST_OR_SUPERSET: assert (op_i != 3'b001 || ((result_o & a_i) == a_i && (result_o & b_i) == b_i)); // R2
      AST_ADD_UNDO: assert (op_i != 3'b010 || (result_o - b_i) == a_i); // R3
      AST_SUB_UNDO: assert (op_i != 3'b110 || (result_o + b_i) == a_i); // R4
      AST_SLT_UPPER: assert (op_i != 3'b111 || result_o[WIDTH-1:1] == '0); // R5
      AST_SLT_SIGNED: assert (op_i != 3'b111 || result_o[0] == ($signed(a_i) < $signed(b_i))); // R5
      AST_SLT_OVF: assert (!(op_i == 3'b111 && ovf_w) || result_o[0] == a_i[WIDTH-1]); // R5
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R6
      AST_UNUSED_CODE: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) || result_o == '0); // R7
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_w(ovf_w)
);

// File: tb/test_alu_core.sv
module test_alu_core;
  localparam int W = 32;
  localparam int PERIOD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic         zf;

  int total = 0;
  int bad   = 0;
  bit driver_done = 0;

  logic [W-1:0] exp_r_q[$];
  logic         exp_z_q[$];
  string        tag_q[$];
  logic [W-1:0] a_q[$], b_q[$];
  logic [2:0]   op_q[$];

  always #(PERIOD/2) clk = ~clk;

  alu_core i_alu_core (.a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zf));

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [2:0] c);
    logic signed [W:0] xs, ys;
    xs = {x[W-1], x};
    ys = {y[W-1], y};
    case (c)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return W'(x + y);
      3'b110: return W'(xs - ys);
      3'b111: return (xs < ys) ? W'(1) : W'(0);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tg, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tg, act, expv);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
    logic [W-1:0] e;
    @(posedge clk);
    a = x; b = y; op = c;
    e = model(x, y, c);
    exp_r_q.push_back(e);
    exp_z_q.push_back(e == '0);
    tag_q.push_back(tag_of(c));
    a_q.push_back(x); b_q.push_back(y); op_q.push_back(c);
  endtask

  // Monitor: pops one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && exp_r_q.size() > 0) begin
        string tg;
        logic [W-1:0] er;
        logic ez;
        tg = tag_q.pop_front();
        er = exp_r_q.pop_front();
        ez = exp_z_q.pop_front();
        void'(a_q.pop_front()); void'(b_q.pop_front()); void'(op_q.pop_front());
        check(tg, res, er);
        check("R6", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, ez});
      end
    end
  end

  initial begin
    logic [W-1:0] corners [8];
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001; corners[5] = 32'h0000_0011;
    corners[6] = 32'h0000_0044; corners[7] = 32'hFFFF_FFCD;
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    // reset state: idle inputs give a zero result and a raised flag (R1, R6)
    check("R1", res, '0);
    check("R6", {31'b0, zf}, 32'd1);
    rst = 1'b0;

    // R8: outputs follow inputs with no clock edge in between
    @(negedge clk);
    a = 32'h0000_0011; b = 32'h0000_0044; op = 3'b110; #0.5;
    check("R8", res, 32'hFFFF_FFCD);
    op = 3'b111; #0.5;
    check("R8", res, 32'h0000_0001);
    a = 32'h0000_0044; #0.5;
    check("R8", {31'b0, zf}, 32'd1);

    // named corner cases
    drive(32'h0000_0011, 32'h0000_0044, 3'b000); // R1 result 0
    drive(32'h0000_0011, 32'h0000_0044, 3'b001); // R2 0x55
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // R3 wrap to zero
    drive(32'h1234_5678, 32'h1234_5678, 3'b110); // R4 equal operands
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b111); // R5 -1 < 1
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b111); // R5 overflow in difference
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111); // R5 overflow other way
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b011); // R7
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b100); // R7
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b101); // R7

    // grid of corner operands over all eight codes
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(corners[i], corners[j], 3'(c));

    // random sweep
    for (int k = 0; k < 400; k++)
      drive($urandom, $urandom, 3'($urandom_range(0, 7)));

    @(posedge clk);
    @(posedge clk);
    driver_done = 1;
  end

  initial begin
    wait (driver_done);
    @(negedge clk);
    if (exp_r_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R8: actual=%0d expected=0 items left in scoreboard", exp_r_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL R8: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule